// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Observation

This block holds the digital counters of a two-loop frequency synthesizer. A crystal-rate tick drives two fixed reference dividers: one by 4 for the first loop and one by 130 for the second loop. A tick from the second-loop VCO drives a feedback divider. Its nominal ratio is 1034, and a test code can move it to 987 or 1081. Every divided signal leaves the block as a registered square wave of roughly 50% duty.

A single test output serves as the observation point. A 7-bit test code sets what it shows. It can show a lock flag: the first-loop flag, the second-loop flag, or both ANDed together. It can also show a scaled copy of one of four divider outputs:
- the first-loop feedback pulses divided by 16;
- the first-loop reference divided by 8;
- the second-loop feedback divided by 2;
- the second-loop reference itself.

Two rules keep the observed signals clean. A new divide ratio is loaded only when the counter wraps. A divided observation clock always starts from its low phase when it is selected. As a result, neither change produces a runt pulse.

Everything runs on one system clock. The crystal tick, the VCO tick and the first-loop feedback pulse are single-cycle enables.

Top module: `synth_div_obs`

## Requirements
- R1: `ref1_clk` has a period of 4 `xtal_en` ticks and is high for 2 of them. It changes only in the cycle after a tick.
- R2: `ref2_clk` has a period of 130 `xtal_en` ticks and is high for 65 of them.
- R3: When `test_code` is neither 7'h40 nor 7'h60, `fb2_clk` has a period of 1034 `vco2_en` ticks and is high for 517. It changes only in the cycle after a tick.
- R4: Code 7'h40 sets the feedback ratio to 987, with `fb2_clk` high for 493 ticks and low for 494. Code 7'h60 sets the ratio to 1081, with `fb2_clk` high for 540 ticks and low for 541.
- R5: A change of feedback ratio takes effect at the next wrap of the counter. The period already under way completes at the old ratio.
- R6: Code 7'h00 drives `test_out` with `rf_lock`. Code 7'h01 drives it with `if_lock`. Code 7'h02 drives it with `rf_lock AND if_lock`. In each case `test_out` is the flag value of the previous cycle: high means locked, low means unlocked.
- R7: With code 7'h03, `test_out` has a period of 16 `fb1_pulse` pulses and is high for 8.
- R8: With code 7'h04, `test_out` has a period of 8 `ref1_clk` periods (32 ticks) and is high for 16 ticks.
- R9: With code 7'h05, `test_out` has a period of 2 `fb2_clk` periods and is high for one full feedback period.
- R10: With code 7'h06, `test_out` shows the `ref2_clk` waveform: a period of 130 ticks, high for 65.
- R11: After a divided-clock code is selected, `test_out` starts low. Its first high phase has full length, with no runt.
- R12: Any other code, including 7'h40 and 7'h60, behaves as code 7'h00.
- R13: During reset all outputs are low. After reset the test code of zero selects `rf_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_en | input | 1 | Crystal-rate tick enable |
| vco2_en | input | 1 | Second-loop VCO tick enable |
| fb1_pulse | input | 1 | First-loop feedback divider terminal pulse |
| rf_lock | input | 1 | First-loop lock flag |
| if_lock | input | 1 | Second-loop lock flag |
| test_code | input | 7 | Observation and ratio test code |
| ref1_clk | output | 1 | First-loop reference square wave |
| ref2_clk | output | 1 | Second-loop reference square wave |
| fb2_clk | output | 1 | Second-loop feedback square wave |
| test_out | output | 1 | Observation output |

## Verification
The bench changes the feedback ratio partway through a period and measures the period under way. A design that loaded the ratio at once would show a shortened or stretched period there, instead of 1034 followed by 987.

The bench also selects a divided observation mode at an arbitrary moment and measures the first high phase. A divider that was not held cleared while deselected would produce a runt.

The odd ratios 987 and 1081 show whether the high and low halves are split with the extra tick on the low side. Undefined codes, and the two ratio codes, are checked to fall back to the first-loop lock flag rather than to a stale or divided source.

// File: rtl/synth_obs_pkg.sv
package synth_obs_pkg;

  typedef enum logic [2:0] {
    OBS_RF, OBS_IF, OBS_BOTH, OBS_PDIV1, OBS_RDIV1, OBS_FDIV2, OBS_RDIV2
  } obs_sel_e;

  typedef enum logic [1:0] {RAT_NOM, RAT_LO, RAT_HI} ratio_sel_e;

  localparam logic [6:0] TC_LOCK_RF   = 7'h00;
  localparam logic [6:0] TC_LOCK_IF   = 7'h01;
  localparam logic [6:0] TC_LOCK_BOTH = 7'h02;
  localparam logic [6:0] TC_PDIV1     = 7'h03;
  localparam logic [6:0] TC_RDIV1     = 7'h04;
  localparam logic [6:0] TC_FDIV2     = 7'h05;
  localparam logic [6:0] TC_RDIV2     = 7'h06;
  localparam logic [6:0] TC_RATIO_LO  = 7'h40;
  localparam logic [6:0] TC_RATIO_HI  = 7'h60;

  function automatic obs_sel_e decode_obs(input logic [6:0] code);
    case (code)
      TC_LOCK_IF:   return OBS_IF;
      TC_LOCK_BOTH: return OBS_BOTH;
      TC_PDIV1:     return OBS_PDIV1;
      TC_RDIV1:     return OBS_RDIV1;
      TC_FDIV2:     return OBS_FDIV2;
      TC_RDIV2:     return OBS_RDIV2;
      default:      return OBS_RF;
    endcase
  endfunction

  function automatic ratio_sel_e decode_ratio(input logic [6:0] code);
    case (code)
      TC_RATIO_LO: return RAT_LO;
      TC_RATIO_HI: return RAT_HI;
      default:     return RAT_NOM;
    endcase
  endfunction

endpackage

// File: rtl/sdo_div_core.sv
module sdo_div_core #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         tc,
  output logic         sq
);
  logic [W-1:0] cnt, ratio_q, nxt, half;
  logic         wrap;

  always_comb begin
    wrap = (cnt == ratio_q - W'(1));
    nxt  = wrap ? '0 : cnt + W'(1);
    // the new ratio governs the duty split from the wrap onward
    half = wrap ? (ratio >> 1) : (ratio_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= ratio - W'(1);
      ratio_q <= ratio;
      tc      <= 1'b0;
      sq      <= 1'b0;
    end else begin
      tc <= tick && wrap;
      if (tick) begin
        cnt <= nxt;
        sq  <= (nxt < half);
        if (wrap) ratio_q <= ratio;
      end
    end
  end
endmodule

// File: rtl/sdo_tog_div.sv
module sdo_tog_div #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tc,
  output logic q
);
  generate
    if (HALF <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst || !en) q <= 1'b0;
        else if (tc)    q <= ~q;
      end
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          cnt <= '0;
          q   <= 1'b0;
        end else if (tc) begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            q   <= ~q;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/synth_div_obs.sv
module synth_div_obs
  import synth_obs_pkg::*;
#(
  parameter int REF1_DIV    = 4,
  parameter int REF2_DIV    = 130,
  parameter int FB2_NOM     = 1034,
  parameter int FB2_TLO     = 987,
  parameter int FB2_THI     = 1081,
  parameter int PDIV1_SCALE = 16,
  parameter int RDIV1_SCALE = 8,
  parameter int FDIV2_SCALE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xtal_en,
  input  logic       vco2_en,
  input  logic       fb1_pulse,
  input  logic       rf_lock,
  input  logic       if_lock,
  input  logic [6:0] test_code,
  output logic       ref1_clk,
  output logic       ref2_clk,
  output logic       fb2_clk,
  output logic       test_out
);
  localparam int R1W    = $clog2(REF1_DIV + 1);
  localparam int R2W    = $clog2(REF2_DIV + 1);
  localparam int FB_MAX = (FB2_THI > FB2_NOM) ? FB2_THI : FB2_NOM;
  localparam int FBW    = $clog2(FB_MAX + 1);

  obs_sel_e       sel;
  ratio_sel_e     rsel;
  logic [FBW-1:0] fb2_ratio;
  logic ref1_tc, ref2_tc, fb2_tc;
  logic pdiv1_q, rdiv1_q, fdiv2_q;

  always_comb begin
    sel  = decode_obs(test_code);
    rsel = decode_ratio(test_code);
    case (rsel)
      RAT_LO:  fb2_ratio = FBW'(FB2_TLO);
      RAT_HI:  fb2_ratio = FBW'(FB2_THI);
      default: fb2_ratio = FBW'(FB2_NOM);
    endcase
  end

  sdo_div_core #(.W(R1W)) u_ref1 (
    .clk(clk), .rst(rst), .tick(xtal_en), .ratio(R1W'(REF1_DIV)),
    .tc(ref1_tc), .sq(ref1_clk));

  sdo_div_core #(.W(R2W)) u_ref2 (
    .clk(clk), .rst(rst), .tick(xtal_en), .ratio(R2W'(REF2_DIV)),
    .tc(ref2_tc), .sq(ref2_clk));

  sdo_div_core #(.W(FBW)) u_fb2 (
    .clk(clk), .rst(rst), .tick(vco2_en), .ratio(fb2_ratio),
    .tc(fb2_tc), .sq(fb2_clk));

  sdo_tog_div #(.HALF(PDIV1_SCALE / 2)) u_pdiv1 (
    .clk(clk), .rst(rst), .en(sel == OBS_PDIV1), .tc(fb1_pulse), .q(pdiv1_q));

  sdo_tog_div #(.HALF(RDIV1_SCALE / 2)) u_rdiv1 (
    .clk(clk), .rst(rst), .en(sel == OBS_RDIV1), .tc(ref1_tc), .q(rdiv1_q));

  sdo_tog_div #(.HALF(FDIV2_SCALE / 2)) u_fdiv2 (
    .clk(clk), .rst(rst), .en(sel == OBS_FDIV2), .tc(fb2_tc), .q(fdiv2_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      test_out <= 1'b0;
    end else begin
      case (sel)
        OBS_IF:    test_out <= if_lock;
        OBS_BOTH:  test_out <= rf_lock & if_lock;
        OBS_PDIV1: test_out <= pdiv1_q;
        OBS_RDIV1: test_out <= rdiv1_q;
        OBS_FDIV2: test_out <= fdiv2_q;
        OBS_RDIV2: test_out <= ref2_clk;
        default:   test_out <= rf_lock;
      endcase
    end
  end

  logic unused_tc;
  assign unused_tc = ref2_tc;
endmodule

// File: rtl/synth_obs_chk.sv
module synth_obs_chk
  import synth_obs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       xtal_en,
  input logic       vco2_en,
  input logic       rf_lock,
  input logic       if_lock,
  input logic [6:0] test_code,
  input logic       ref1_clk,
  input logic       ref2_clk,
  input logic       fb2_clk,
  input logic       test_out
);
  // R6, R12: lock-class codes follow the first-loop flag one cycle later
  a_r12_rf_flag: assert property (@(posedge clk) disable iff (rst)
    (decode_obs(test_code) == OBS_RF) |=> (test_out == $past(rf_lock)));

  a_r6_if_flag: assert property (@(posedge clk) disable iff (rst)
    (test_code == TC_LOCK_IF) |=> (test_out == $past(if_lock)));

  a_r6_both_flags: assert property (@(posedge clk) disable iff (rst)
    (test_code == TC_LOCK_BOTH) |=> (test_out == $past(rf_lock && if_lock)));

  // R1, R2: references only move after a crystal tick
  a_r1_ref_hold: assert property (@(posedge clk) disable iff (rst)
    !xtal_en |=> ($stable(ref1_clk) && $stable(ref2_clk)));

  // R3: feedback clock only moves after a VCO tick
  a_r3_fb2_hold: assert property (@(posedge clk) disable iff (rst)
    !vco2_en |=> $stable(fb2_clk));
endmodule

bind synth_div_obs synth_obs_chk u_chk (.*);

// File: tb/sim_synth_div_obs.sv
module sim_synth_div_obs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xtal_en = 1'b0, vco2_en = 1'b0, fb1_pulse = 1'b0;
  logic rf_lock = 1'b0, if_lock = 1'b0;
  logic [6:0] test_code = 7'h00;
  logic ref1_clk, ref2_clk, fb2_clk, test_out;

  int checks = 0, bad = 0, xgap = 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_div_obs u0 (.*);

  typedef struct packed {
    logic [6:0]  code;
    logic        rf;
    logic        ifl;
    logic [15:0] per;
    logic [15:0] hi;
  } vec_t;

  // per == 0: static level expected in hi[0]
  localparam vec_t TBL [14] = '{
    '{7'h00, 1'b1, 1'b0, 16'd0,    16'd1},
    '{7'h00, 1'b0, 1'b1, 16'd0,    16'd0},
    '{7'h01, 1'b0, 1'b1, 16'd0,    16'd1},
    '{7'h01, 1'b1, 1'b0, 16'd0,    16'd0},
    '{7'h02, 1'b1, 1'b1, 16'd0,    16'd1},
    '{7'h02, 1'b1, 1'b0, 16'd0,    16'd0},
    '{7'h03, 1'b0, 1'b0, 16'd16,   16'd8},
    '{7'h04, 1'b0, 1'b0, 16'd32,   16'd16},
    '{7'h05, 1'b0, 1'b0, 16'd2068, 16'd1034},
    '{7'h06, 1'b0, 1'b0, 16'd130,  16'd65},
    '{7'h7F, 1'b1, 1'b0, 16'd0,    16'd1},
    '{7'h7F, 1'b0, 1'b1, 16'd0,    16'd0},
    '{7'h40, 1'b1, 1'b0, 16'd0,    16'd1},
    '{7'h11, 1'b0, 1'b1, 16'd0,    16'd0}
  };

  initial begin : gen_ticks
    int xc = 0;
    forever begin
      @(negedge clk);
      if (xc + 1 >= xgap) begin xtal_en = 1'b1; xc = 0; end
      else begin xtal_en = 1'b0; xc++; end
      vco2_en   = 1'b1;
      fb1_pulse = 1'b1;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic pick(input int s);
    case (s)
      1:       return ref1_clk;
      2:       return ref2_clk;
      3:       return fb2_clk;
      default: return test_out;
    endcase
  endfunction

  task automatic wait_rise(input int s, output bit ok);
    logic prev = pick(s);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!prev && pick(s)) begin ok = 1; break; end
      prev = pick(s);
    end
  endtask

  task automatic measure(input int s, output int hi, output int lo);
    bit ok;
    hi = -1; lo = -1;
    wait_rise(s, ok);
    if (ok) begin
      hi = 1;
      forever begin @(negedge clk); if (!pick(s)) break; hi++; end
      lo = 1;
      forever begin @(negedge clk); if (pick(s)) break; lo++; end
    end
  endtask

  initial begin : main
    int hi, lo, n;
    bit ok;
    repeat (4) @(negedge clk);
    // R13: reset state
    check("R13 reset ref1", ref1_clk, 0);
    check("R13 reset ref2", ref2_clk, 0);
    check("R13 reset fb2", fb2_clk, 0);
    check("R13 reset test_out", test_out, 0);
    rf_lock = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 code zero follows rf_lock", test_out, 1);

    // table walk: R6 R7 R8 R9 R10 R11 R12
    foreach (TBL[i]) begin
      test_code = TBL[i].code;
      rf_lock   = TBL[i].rf;
      if_lock   = TBL[i].ifl;
      if (TBL[i].per == 0) begin
        repeat (3) @(negedge clk);
        check($sformatf("R6/R12 level code %0h", TBL[i].code), test_out, int'(TBL[i].hi));
      end else begin
        repeat (37) @(negedge clk);
        measure(0, hi, lo);   // first high after selection must be full (R11)
        check($sformatf("R11 first high code %0h", TBL[i].code), hi, int'(TBL[i].hi));
        measure(0, hi, lo);
        check($sformatf("R7-10 period code %0h", TBL[i].code), hi + lo, int'(TBL[i].per));
      end
    end

    // R1, R2 with every-cycle and sparse crystal ticks
    test_code = 7'h00;
    measure(1, hi, lo);
    check("R1 ref1 high", hi, 2);
    check("R1 ref1 low", lo, 2);
    measure(2, hi, lo);
    check("R2 ref2 high", hi, 65);
    check("R2 ref2 low", lo, 65);
    xgap = 3;
    repeat (20) @(negedge clk);
    measure(1, hi, lo);
    check("R1 ref1 high sparse", hi, 6);
    check("R1 ref1 period sparse", hi + lo, 12);
    xgap = 1;

    // R3 nominal ratio
    measure(3, hi, lo);
    check("R3 fb2 high", hi, 517);
    check("R3 fb2 low", lo, 517);

    // R5: ratio change mid-period; then R4 low ratio
    wait_rise(3, ok);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 100) test_code = 7'h40;
      if (fb2_clk && n > 600) break;
    end
    check("R5 period in progress keeps old ratio", n, 1034);
    hi = 1;
    forever begin @(negedge clk); if (!fb2_clk) break; hi++; end
    lo = 1;
    forever begin @(negedge clk); if (fb2_clk) break; lo++; end
    check("R4 987 high", hi, 493);
    check("R4 987 low", lo, 494);

    test_code = 7'h60;
    measure(3, hi, lo);
    measure(3, hi, lo);
    check("R4 1081 high", hi, 540);
    check("R4 1081 low", lo, 541);

    // R11: select divide-by-2 observation at an odd moment
    test_code = 7'h00;
    repeat (1200) @(negedge clk);
    repeat (313) @(negedge clk);
    test_code = 7'h05;
    measure(0, hi, lo);
    check("R11 fb2/2 first high full", hi, 1034);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule